// File: doc/BRIEF.md
# Configuration Stream Sync Tracker

This block listens passively to the byte stream that is being written into a device configuration port. It tracks whether that port would currently be synchronized, and it presents the status byte the port would return. Before synchronization it slides a 32-bit window over the incoming bytes, so the start marker is found at any byte offset. Once the marker is found, word boundaries are locked to it, and only whole, aligned words are tested for the end marker.

While the port is synchronized, a 32-bit counter advances on every clock. When the end marker arrives, the counter freezes. Its value is then the length, in clock cycles, of the interval in which configuration frames were being loaded. A supervisor reads this value to report reconfiguration time. Packet types other than the two markers are not decoded.

Top module: `cfg_sync_tracker`

## Requirements
- R1: While reset is high and in the first cycle after it, `status_byte` is 8'h9F, `synced` is 0, both pulses are 0 and `sync_cycles` is 0.
- R2: While unsynchronized, every valid byte is shifted into a 32-bit window, first byte in the most significant position. When the window equals 32'h5599AA66, the following happens after the clock edge that captures the last byte: `synced` becomes 1, `status_byte` becomes 8'hDF, and `sync_seen` is high for exactly one cycle. This holds whatever bytes came before the marker.
- R3: A cycle with `in_valid` low shifts nothing, does not advance the word position, and never completes a marker.
- R4: After synchronization, the first valid byte after the start marker is byte 0 of a word. The end marker is recognized only when it occupies byte positions 0 to 3 of such a word. The same bytes at any other offset leave the block synchronized.
- R5: An aligned word equal to 32'h000000B0 while synchronized has the following effect after the edge that captures its last byte: `synced` becomes 0, `status_byte` becomes 8'h9F, and `desync_seen` is high for exactly one cycle.
- R6: The end marker received while unsynchronized produces no `desync_seen` pulse and leaves the status at 8'h9F.
- R7: `sync_cycles` reads 0 in the cycle `sync_seen` is high. It then rises by one on every clock edge while synchronized, the edge that ends synchronization included. The frozen value therefore equals the number of cycles `status_byte` read 8'hDF.
- R8: After desynchronization, `sync_cycles` holds its value through any input until the next start marker.
- R9: A start marker received while synchronized produces no `sync_seen` pulse, does not clear `sync_cycles`, and does not move the word alignment.
- R10: A start marker after a desynchronization restarts `sync_cycles` from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte strobe for `in_byte` |
| in_byte | input | 8 | Configuration stream byte |
| status_byte | output | 8 | Port status: 8'h9F idle, 8'hDF synchronized |
| synced | output | 1 | High while synchronized |
| sync_seen | output | 1 | One-cycle pulse when the start marker is accepted |
| desync_seen | output | 1 | One-cycle pulse when the end marker is accepted |
| sync_cycles | output | 32 | Clock count of the current or last synchronized interval |

## Verification
Each result is registered once. The status byte, the flag and both pulses change directly after the clock edge that samples the final marker byte. The counter shows the value for that edge at the same moment, so every result is due one edge after its stimulus. The bench drives each byte on a falling edge and samples all outputs a quarter period after the following rising edge. It compares them with a cycle-accurate reference that it updates in the same step, so an output that arrives one cycle early or late is reported. The directed sequences end with exact counter values that were counted by hand, for example 16 cycles for a sixteen-byte synchronized run.

// File: rtl/cst_pkg.sv
package cst_pkg;

    localparam int BYTE_W     = 8;
    localparam int WORD_BYTES = 4;
    localparam int WORD_W     = BYTE_W * WORD_BYTES;
    localparam int IDX_W      = $clog2(WORD_BYTES);

    localparam logic [WORD_W-1:0] SYNC_WORD   = 32'h5599_AA66;
    localparam logic [WORD_W-1:0] DESYNC_WORD = 32'h0000_00B0;

    localparam logic [BYTE_W-1:0] STATUS_IDLE   = 8'h9F;
    localparam logic [BYTE_W-1:0] STATUS_LOCKED = 8'hDF;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_LOCKED = 1'b1
    } link_state_e;

    typedef struct packed {
        logic              valid;
        logic              aligned;
        logic [WORD_W-1:0] word;
    } word_view_t;

    function automatic logic [BYTE_W-1:0] status_of(link_state_e st);
        return (st == ST_LOCKED) ? STATUS_LOCKED : STATUS_IDLE;
    endfunction

endpackage

// File: rtl/cst_byte_window.sv
module cst_byte_window
    import cst_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              realign,
    output word_view_t        view
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_BYTES - 1);

    logic [WORD_W-1:0] window_q;
    logic [IDX_W-1:0]  pos_q;

    always_comb begin
        view.valid   = in_valid;
        view.aligned = (pos_q == LAST_IDX);
        view.word    = {window_q[WORD_W-BYTE_W-1:0], in_byte};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            window_q <= '0;
            pos_q    <= '0;
        end else if (in_valid) begin
            window_q <= view.word;
            if (realign || pos_q == LAST_IDX) begin
                pos_q <= '0;
            end else begin
                pos_q <= pos_q + 1'b1;
            end
        end
    end

    // R3: no valid byte, no movement of the word position
    a_r3_pos_frozen: assert property (@(posedge clk) disable iff (rst)
        !$past(in_valid) && !$past(rst) |-> $stable(pos_q) && $stable(window_q));

endmodule

// File: rtl/cst_sync_fsm.sv
module cst_sync_fsm
    import cst_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  word_view_t        view,
    output logic              sync_hit,
    output link_state_e       state_q,
    output logic              sync_pulse,
    output logic              desync_pulse,
    output logic [BYTE_W-1:0] status_q
);

    logic        desync_hit;
    link_state_e state_d;

    always_comb begin
        sync_hit   = view.valid && (state_q == ST_IDLE) && (view.word == SYNC_WORD);
        desync_hit = view.valid && (state_q == ST_LOCKED) && view.aligned
                     && (view.word == DESYNC_WORD);
        state_d = state_q;
        if (sync_hit) begin
            state_d = ST_LOCKED;
        end else if (desync_hit) begin
            state_d = ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            sync_pulse   <= 1'b0;
            desync_pulse <= 1'b0;
            status_q     <= STATUS_IDLE;
        end else begin
            state_q      <= state_d;
            sync_pulse   <= sync_hit;
            desync_pulse <= desync_hit;
            status_q     <= status_of(state_d);
        end
    end

    logic locked;
    assign locked = (state_q == ST_LOCKED);

    // R2: entering the locked state is always announced
    a_r2_rise_announced: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> sync_pulse);

    // R5: a desync pulse means the block just left the locked state
    a_r5_desync_drop: assert property (@(posedge clk) disable iff (rst)
        desync_pulse |-> !locked && $past(locked));

    // R6: no desync pulse unless previously locked
    a_r6_idle_ignores_desync: assert property (@(posedge clk) disable iff (rst)
        !$past(locked) |-> !desync_pulse);

    // R9: a sync pulse only follows an idle cycle
    a_r9_no_resync: assert property (@(posedge clk) disable iff (rst)
        sync_pulse |-> !$past(locked));

    a_r2_pulses_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sync_pulse, desync_pulse}));

endmodule

// File: rtl/cst_interval_counter.sv
module cst_interval_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             run,
    output logic [CNT_W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (run) begin
            count <= count + 1'b1;
        end
    end

    // R8: neither running nor cleared means the value is held
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && !$past(run) && !$past(clear) |-> $stable(count));

endmodule

// File: rtl/cfg_sync_tracker.sv
module cfg_sync_tracker
    import cst_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output logic [BYTE_W-1:0] status_byte,
    output logic              synced,
    output logic              sync_seen,
    output logic              desync_seen,
    output logic [CNT_W-1:0]  sync_cycles
);

    word_view_t  view;
    logic        sync_hit;
    link_state_e state;

    cst_byte_window u_window (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_byte  (in_byte),
        .realign  (sync_hit),
        .view     (view)
    );

    cst_sync_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .view         (view),
        .sync_hit     (sync_hit),
        .state_q      (state),
        .sync_pulse   (sync_seen),
        .desync_pulse (desync_seen),
        .status_q     (status_byte)
    );

    assign synced = (state == ST_LOCKED);

    cst_interval_counter #(.CNT_W(CNT_W)) u_counter (
        .clk   (clk),
        .rst   (rst),
        .clear (sync_hit),
        .run   (synced),
        .count (sync_cycles)
    );

    // R7: counter starts at zero together with the sync pulse
    a_r7_zero_on_sync: assert property (@(posedge clk) disable iff (rst)
        sync_seen |-> sync_cycles == '0);

    // R7: every locked cycle adds exactly one
    a_r7_step: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(synced) && !sync_seen
        |-> sync_cycles == $past(sync_cycles) + 1'b1);

    // R2, R5: status byte agrees with the flag
    a_r2_status_tracks_flag: assert property (@(posedge clk) disable iff (rst)
        status_byte == (synced ? STATUS_LOCKED : STATUS_IDLE));

endmodule

// File: tb/cfg_sync_tracker_tb.sv
module cfg_sync_tracker_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic [7:0]  status_byte;
    logic        synced, sync_seen, desync_seen;
    logic [31:0] sync_cycles;

    cfg_sync_tracker u_dut (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_byte     (in_byte),
        .status_byte (status_byte),
        .synced      (synced),
        .sync_seen   (sync_seen),
        .desync_seen (desync_seen),
        .sync_cycles (sync_cycles)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference model state
    logic [31:0] m_win;
    bit          m_lock;
    int          m_pos;
    logic [31:0] m_cnt;
    bit          m_sp, m_dp;

    function automatic logic [7:0] exp_status(bit lk);
        return lk ? 8'hDF : 8'h9F;
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_win = '0; m_lock = 0; m_pos = 0; m_cnt = '0; m_sp = 0; m_dp = 0;
    endtask

    task automatic model_step(bit v, logic [7:0] b);
        logic [31:0] w;
        w = {m_win[23:0], b};
        m_sp = 0; m_dp = 0;
        if (m_lock) m_cnt = m_cnt + 1;
        if (v) begin
            if (!m_lock) begin
                if (w == 32'h5599AA66) begin
                    m_lock = 1; m_sp = 1; m_cnt = 0; m_pos = 0;
                end
            end else begin
                if (m_pos == 3 && w == 32'h000000B0) begin
                    m_lock = 0; m_dp = 1;
                end
                m_pos = (m_pos + 1) % 4;
            end
            m_win = w;
        end
    endtask

    task automatic step(bit v, logic [7:0] b);
        @(negedge clk);
        in_valid = v;
        in_byte  = b;
        model_step(v, b);
        @(posedge clk);
        #5;
        chk(status_byte == exp_status(m_lock) && synced == m_lock,
            "R2 R5 status", {23'd0, synced, status_byte}, {23'd0, m_lock, exp_status(m_lock)});
        chk(sync_seen == m_sp && desync_seen == m_dp, "R2 R5 pulses",
            {sync_seen, desync_seen}, {m_sp, m_dp});
        chk(sync_cycles == m_cnt, "R7 R8 count", sync_cycles, m_cnt);
    endtask

    task automatic send_word(logic [31:0] w, bit gaps);
        for (int i = 3; i >= 0; i--) begin
            if (gaps) step(1'b0, 8'($urandom));
            step(1'b1, w[i*8 +: 8]);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: reset values while reset is held
        chk(status_byte == 8'h9F && !synced && !sync_seen && !desync_seen && sync_cycles == 0,
            "R1 reset", {status_byte, synced, sync_seen, desync_seen}, {8'h9F, 3'b000});
        rst = 1'b0;
        step(1'b0, 8'h00);
        chk(status_byte == 8'h9F && sync_cycles == 0, "R1 after reset", status_byte, 8'h9F);

        // R2: marker found after three unrelated bytes (unaligned offset)
        step(1'b1, 8'hA1); step(1'b1, 8'hB2); step(1'b1, 8'hC3);
        send_word(32'h5599AA66, 0);
        chk(synced && sync_seen && status_byte == 8'hDF, "R2 sync detect",
            {status_byte, sync_seen}, {8'hDF, 1'b1});

        // R9: repeated marker while locked
        send_word(32'h5599AA66, 0);
        chk(!sync_seen && sync_cycles == 4, "R9 resync ignored", sync_cycles, 32'd4);

        // R4: end marker off by one byte
        step(1'b1, 8'h00);
        send_word(32'h000000B0, 0);
        chk(synced && !desync_seen, "R4 misaligned desync ignored", synced, 1);
        step(1'b1, 8'h11); step(1'b1, 8'h22); step(1'b1, 8'h33);

        // R5, R7: aligned end marker, sixteen locked cycles
        send_word(32'h000000B0, 0);
        chk(!synced && desync_seen && status_byte == 8'h9F, "R5 desync",
            {status_byte, desync_seen}, {8'h9F, 1'b1});
        chk(sync_cycles == 16, "R7 interval length", sync_cycles, 32'd16);

        // R8: value held while idle and during random traffic
        repeat (5) step(1'b0, 8'h00);
        step(1'b1, 8'h5A); step(1'b1, 8'hC0);
        chk(sync_cycles == 16, "R8 hold", sync_cycles, 32'd16);

        // R6: end marker while idle
        send_word(32'h000000B0, 0);
        chk(!desync_seen && status_byte == 8'h9F, "R6 idle desync ignored",
            {status_byte, desync_seen}, {8'h9F, 1'b0});

        // R3, R10: markers spread over invalid cycles
        send_word(32'h5599AA66, 1);
        chk(sync_seen && sync_cycles == 0, "R10 restart", sync_cycles, 32'd0);
        step(1'b1, 8'h77); step(1'b0, 8'hB0); step(1'b1, 8'h88);
        step(1'b1, 8'h99); step(1'b1, 8'hAA);
        send_word(32'h000000B0, 1);
        chk(desync_seen && sync_cycles == 13, "R3 gaps keep alignment", sync_cycles, 32'd13);

        // random traffic with injected markers
        for (int n = 0; n < 3000; n++) begin
            int sel;
            sel = $urandom_range(0, 99);
            if (sel < 3)      send_word(32'h5599AA66, $urandom_range(0, 1) == 1);
            else if (sel < 7) send_word(32'h000000B0, $urandom_range(0, 1) == 1);
            else              step($urandom_range(0, 9) < 8, 8'($urandom));
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule